// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a byte-wide printer port reached over a simple host I/O bus. It decodes three adjacent port addresses: a data port, a status port and a control port. The host writes a character into the data port. That byte appears at once on eight parallel output lines and stays there until the next write. The host then writes 1 and then 0 to the strobe bit of the control port, which gives the printer a strobe pulse telling it to latch the lines.

The printer reports whether it can take another byte on a single ready line. The block brings that line across a flop synchronizer and shows it in the top bit of the status port. Software polls the status port until that bit reads 1 before it sends the next character. The bus is the dedicated port space of the host, so there are no memory-style accesses, and an access to any other address has no effect.

Top module: `lpt_port`

## Requirements
- R1: After reset, lp_data is 0x00, lp_strobe is 0 and io_rdata is 0xFF.
- R2: A write (io_wr high) to address BASE_ADDR (0x378) loads io_wdata. The byte appears on lp_data from the next clock edge. lp_data keeps its value until the next write to that address.
- R3: A read (io_rd high) of BASE_ADDR returns the byte now held on lp_data. io_rdata updates at the clock edge that samples io_rd and then holds until the next read.
- R4: A write to BASE_ADDR+2 (0x37A) sets lp_strobe to io_wdata bit 0 from the next edge. A read of that address returns 0x00 or 0x01, which is the current strobe value in bit 0.
- R5: A read of BASE_ADDR+1 (0x379) returns the synchronized lp_ready in bit 7, with 1 meaning ready. Bits 6..0 read 0. A change on lp_ready reaches the status value only after SYNC_STAGES clock edges.
- R6: Reads of any address other than the three ports return 0xFF. Writes to such addresses leave lp_data and lp_strobe unchanged.
- R7: The status port is read-only. A write to BASE_ADDR+1 changes neither lp_data nor lp_strobe.
- R8: A complete character transfer works without loss. The host polls until ready, writes the byte, and pulses strobe with 1 then 0. The printer latches that byte on the strobe's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W (10) | I/O port address |
| io_wr | input | 1 | Write strobe of the I/O bus, one cycle per access |
| io_rd | input | 1 | Read strobe of the I/O bus, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered on the sampling edge |
| lp_data | output | 8 | Parallel data lines to the printer |
| lp_strobe | output | 1 | Strobe line to the printer |
| lp_ready | input | 1 | Printer ready line, asynchronous, 1 means ready |

## Verification
The bench builds the block with its defaults: a 10-bit port address, a base of 0x378 and a two-stage synchronizer. With these values the whole port space can be reached, so random misses fall well away from the port window and also right beside it at 0x377 and 0x37B.

The two-flop depth keeps the ready latency short. A directed read can therefore catch the stale status value just before the new level arrives. A printer model takes complete transfers and goes busy after each strobe, so the polling loop sees both status values.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int LPT_DW     = 8;
    localparam int READY_BIT  = 7;
    localparam int STROBE_BIT = 0;
    localparam int NUM_PORTS  = 3;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } lpt_sel_e;

    typedef struct packed {
        logic [LPT_DW-1:0] data;
        logic              strobe;
        logic [LPT_DW-1:0] rdata;
    } lpt_state_t;
endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
    import lpt_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h378
) (
    input  logic [ADDR_W-1:0] io_addr,
    output lpt_sel_e          sel
);
    logic [NUM_PORTS-1:0] hit;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hit
        assign hit[i] = (io_addr == BASE_ADDR + ADDR_W'(i));
    end

    always_comb begin
        sel = SEL_NONE;
        if (hit[0])      sel = SEL_DATA;
        else if (hit[1]) sel = SEL_STAT;
        else if (hit[2]) sel = SEL_CTRL;
    end
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
    import lpt_pkg::*;
(
    input  lpt_sel_e          sel,
    input  logic [LPT_DW-1:0] data,
    input  logic              strobe,
    input  logic              ready_s,
    output logic [LPT_DW-1:0] value
);
    always_comb begin
        value = '1;
        case (sel)
            SEL_DATA: value = data;
            SEL_STAT: begin
                value = '0;
                value[READY_BIT] = ready_s;
            end
            SEL_CTRL: begin
                value = '0;
                value[STROBE_BIT] = strobe;
            end
            default:  value = '1;
        endcase
    end
endmodule

// File: rtl/lpt_port.sv
module lpt_port
    import lpt_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h378,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [7:0]        lp_data,
    output logic              lp_strobe,
    input  logic              lp_ready
);
    lpt_sel_e          sel;
    logic              ready_s;
    logic [LPT_DW-1:0] rd_val;
    lpt_state_t        st_d, st_q;

    lpt_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr (io_addr),
        .sel     (sel)
    );

    lpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lp_ready),
        .sync_out (ready_s)
    );

    lpt_rd_mux u_mux (
        .sel     (sel),
        .data    (st_q.data),
        .strobe  (st_q.strobe),
        .ready_s (ready_s),
        .value   (rd_val)
    );

    always_comb begin
        st_d = st_q;
        if (io_wr) begin
            case (sel)
                SEL_DATA: st_d.data   = io_wdata;
                SEL_CTRL: st_d.strobe = io_wdata[STROBE_BIT];
                default:  ;
            endcase
        end
        if (io_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data   <= '0;
            st_q.strobe <= 1'b0;
            st_q.rdata  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata  = st_q.rdata;
    assign lp_data   = st_q.data;
    assign lp_strobe = st_q.strobe;
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk #(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h378
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [7:0]        lp_data,
    input logic              lp_strobe
);
    logic at_data, at_stat, at_ctrl, at_any;
    assign at_data = (io_addr == BASE_ADDR);
    assign at_stat = (io_addr == BASE_ADDR + ADDR_W'(1));
    assign at_ctrl = (io_addr == BASE_ADDR + ADDR_W'(2));
    assign at_any  = at_data | at_stat | at_ctrl;

    // R2
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_data) |=> (lp_data == $past(io_wdata)));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_data) |=> $stable(lp_data));

    // R4
    strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_ctrl) |=> (lp_strobe == $past(io_wdata[0])));

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_ctrl) |=> $stable(lp_strobe));

    // R6
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !at_any) |=> (io_rdata == 8'hFF));

    // R5
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_stat) |=> (io_rdata[6:0] == 7'd0));

    // R3
    data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_data && !io_wr) |=> (io_rdata == $past(lp_data)));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

bind lpt_port lpt_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .lp_data   (lp_data),
    .lp_strobe (lp_strobe)
);

// File: tb/lpt_port_test.sv
module lpt_port_test;
    localparam logic [9:0] A_DATA = 10'h378;
    localparam logic [9:0] A_STAT = 10'h379;
    localparam logic [9:0] A_CTRL = 10'h37A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [7:0] lp_data;
    logic       lp_strobe;
    logic       lp_ready;

    logic       prn_en = 1'b0;
    logic       man_ready = 1'b1;
    logic       prn_ready = 1'b1;
    logic       stb_prev = 1'b0;
    logic [3:0] busy_cnt = '0;
    logic [7:0] prn_got = '0;
    int         prn_count = 0;

    int total = 0;
    int bad = 0;

    logic [7:0] m_data = 8'h00;
    logic       m_strobe = 1'b0;

    always #4 clk = ~clk;

    assign lp_ready = prn_en ? prn_ready : man_ready;

    lpt_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .lp_data(lp_data), .lp_strobe(lp_strobe), .lp_ready(lp_ready)
    );

    // printer model: latch on strobe rise, then busy for a few cycles
    always @(posedge clk) begin
        stb_prev <= lp_strobe;
        if (lp_strobe && !stb_prev) begin
            prn_got   <= lp_data;
            prn_count <= prn_count + 1;
            prn_ready <= 1'b0;
            busy_cnt  <= 4'd6;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 4'd1;
            if (busy_cnt == 4'd1) prn_ready <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [9:0] a, input logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [9:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        v = io_rdata;
    endtask

    function automatic logic [7:0] exp_read(input logic [9:0] a, input logic rdy);
        if (a == A_DATA) return m_data;
        if (a == A_STAT) return {rdy, 7'd0};
        if (a == A_CTRL) return {7'd0, m_strobe};
        return 8'hFF;
    endfunction

    function automatic void model_write(input logic [9:0] a, input logic [7:0] v);
        if (a == A_DATA) m_data = v;
        else if (a == A_CTRL) m_strobe = v[0];
    endfunction

    task automatic send_char(input logic [7:0] c);
        logic [7:0] st;
        int n;
        n = 0;
        st = 8'h00;
        while (st[7] == 1'b0 && n < 100) begin
            io_read(A_STAT, st);
            n++;
        end
        check("R8 poll ready", {7'd0, st[7]}, 8'h01);
        io_write(A_DATA, c);
        io_write(A_CTRL, 8'h01);
        io_write(A_CTRL, 8'h00);
        m_data = c; m_strobe = 1'b0;
        @(negedge clk);
        check("R8 printer byte", prn_got, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [9:0] a;
        int         pre;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1 lp_data", lp_data, 8'h00);
        check("R1 lp_strobe", {7'd0, lp_strobe}, 8'h00);
        check("R1 io_rdata", io_rdata, 8'hFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R3
        io_write(A_DATA, 8'hA5); m_data = 8'hA5;
        check("R2 data drive", lp_data, 8'hA5);
        repeat (4) @(negedge clk);
        check("R2 data hold", lp_data, 8'hA5);
        io_read(A_DATA, v);
        check("R3 data read", v, 8'hA5);
        repeat (2) @(negedge clk);
        check("R3 rdata hold", io_rdata, 8'hA5);

        // R4
        io_write(A_CTRL, 8'hFF); m_strobe = 1'b1;
        check("R4 strobe high", {7'd0, lp_strobe}, 8'h01);
        io_read(A_CTRL, v);
        check("R4 ctrl read 1", v, 8'h01);
        io_write(A_CTRL, 8'hFE); m_strobe = 1'b0;
        check("R4 strobe low", {7'd0, lp_strobe}, 8'h00);
        io_read(A_CTRL, v);
        check("R4 ctrl read 0", v, 8'h00);

        // R5 synchronizer latency
        man_ready = 1'b0;
        repeat (4) @(negedge clk);
        io_read(A_STAT, v);
        check("R5 not ready", v, 8'h00);
        @(negedge clk);
        man_ready = 1'b1;
        io_read(A_STAT, v);
        check("R5 sync delay", v, 8'h00);
        repeat (2) @(negedge clk);
        io_read(A_STAT, v);
        check("R5 ready", v, 8'h80);

        // R6 neighbours of the window
        io_write(10'h377, 8'h3C);
        io_write(10'h37B, 8'h01);
        check("R6 miss data", lp_data, 8'hA5);
        check("R6 miss strobe", {7'd0, lp_strobe}, 8'h00);
        io_read(10'h377, v);
        check("R6 miss read lo", v, 8'hFF);
        io_read(10'h37B, v);
        check("R6 miss read hi", v, 8'hFF);

        // R7
        io_write(A_STAT, 8'h01);
        check("R7 stat wr data", lp_data, 8'hA5);
        check("R7 stat wr strobe", {7'd0, lp_strobe}, 8'h00);

        // R8 transfers through the printer model
        prn_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pre = prn_count;
            send_char(8'h41 + 8'(i));
            check("R8 one latch", 8'(prn_count - pre), 8'h01);
        end
        repeat (10) @(negedge clk);
        prn_en = 1'b0;
        man_ready = 1'b1;
        repeat (3) @(negedge clk);

        // random mix, ready held at 1
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 8;
            case (r)
                0, 1, 2: a = A_DATA;
                3:       a = A_STAT;
                4, 5:    a = A_CTRL;
                default: begin
                    a = 10'($urandom);
                    if (a >= A_DATA && a <= A_CTRL) a = a ^ 10'h100;
                end
            endcase
            if ($urandom % 2 == 0) begin
                v = 8'($urandom);
                io_write(a, v);
                model_write(a, v);
                check("R2 R6 R7 rand data", lp_data, m_data);
                check("R4 R6 R7 rand strobe", {7'd0, lp_strobe}, {7'd0, m_strobe});
            end else begin
                io_read(a, v);
                check("R3 R4 R5 R6 rand read", v, exp_read(a, 1'b1));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule